// File: doc/BRIEF.md
# Shared-Pin Bank Address Splitter

This block is the bus front end of a processor whose eight data pins also carry the top byte of a 24-bit address. Each bus cycle starts on a falling edge of the phase-2 clock. While the clock is low, the shared pins present address bits 23:16. While it is high, they carry the data byte. A transparent latch catches the bank byte during the low phase and holds it through the high phase, so the external 24-bit address stays stable for the whole cycle.

In the high phase the shared pins are driven only when the cycle writes. In a read cycle the memory drives them, and the byte on the pins is registered at the falling edge that closes the cycle. A bus-enable input releases the address, the read/write line and the shared pins as soon as it drops, without waiting for a clock edge. This lets another bus master take the bus. A 16-bit value takes two back-to-back cycles on the 8-bit shared path. The core sequences those cycles; this block treats each cycle on its own.

Top module: `bank_addr_demux`

## Requirements
- R1: While `clk` is low and `bus_en` is 1, `pins_oe` is 1 and `pins_o` equals `core_addr[23:16]`. `ext_addr` equals `core_addr` and `addr_oe` is 1.
- R2: While `clk` is high, `ext_addr[23:16]` keeps the value that `core_addr[23:16]` had at the rising edge, even if `core_addr` changes. `ext_addr[15:0]` follows `core_addr[15:0]` at all times.
- R3: While `clk` is high in a write cycle (`core_rw_n` = 0) with `bus_en` = 1, `pins_oe` is 1 and `pins_o` equals `core_wdata`.
- R4: While `clk` is high in a read cycle (`core_rw_n` = 1), `pins_oe` is 0.
- R5: Whenever `bus_en` is 0, `pins_oe`, `addr_oe` and `rw_oe` are 0 in either phase. This takes effect combinationally, without a clock edge.
- R6: At a falling edge of `clk` where `core_rw_n` = 1, `bus_en` = 1 and `rst` = 0, `rd_data` takes the value of `pins_i` and `rd_valid` becomes 1. Both hold until the next falling edge.
- R7: At a falling edge that closes a write cycle, or a cycle with `bus_en` = 0, `rd_valid` becomes 0 and `rd_data` keeps its previous value.
- R8: A falling edge with `rst` = 1 sets `rd_data` to 0 and `rd_valid` to 0.
- R9: `rw_o` equals `core_rw_n` (1 = read, 0 = write), and `rw_oe` equals `bus_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-2 clock; low = address half, high = data half |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| bus_en | input | 1 | Asynchronous enable for address, strobe and shared-pin drivers |
| core_rw_n | input | 1 | Cycle direction from the core: 1 read, 0 write |
| core_addr | input | 24 | Address from the core, changed after a falling edge |
| core_wdata | input | 8 | Write byte from the core |
| pins_i | input | 8 | Value seen on the shared pins |
| ext_addr | output | 24 | External address with latched bank byte |
| addr_oe | output | 1 | Driver enable for `ext_addr` |
| rw_o | output | 1 | Read/write strobe to the bus |
| rw_oe | output | 1 | Driver enable for `rw_o` |
| pins_o | output | 8 | Value to drive on the shared pins |
| pins_oe | output | 1 | Driver enable for the shared pins |
| rd_data | output | 8 | Byte captured at the end of the last read cycle |
| rd_valid | output | 1 | 1 when `rd_data` was captured at the last falling edge |

## Verification
A bank latch in the wrong state can let a core address change leak into the upper address byte in the high phase. That shows at `ext_addr` within the same half cycle. A wrong drive decision is visible at `pins_oe` at once, and that includes a driver left on in the data half of a read or while the bus is released. This is why every phase of every cycle is sampled. A wrong capture register shows at `rd_data` and `rd_valid` one falling edge after the read closes. The bench compares these against bytes computed from the address.

// File: rtl/bad_pkg.sv
package bad_pkg;

    localparam int ADDR_W_DEF = 24;
    localparam int DATA_W_DEF = 8;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_t;

    function automatic phase_t phase_of(input logic clk_level);
        return clk_level ? PH_DATA : PH_ADDR;
    endfunction

    function automatic logic shared_drive(input phase_t ph,
                                          input logic rw_n,
                                          input logic en);
        logic want;
        want = (ph == PH_ADDR) ? 1'b1 : ~rw_n;
        return want & en;
    endfunction

    function automatic logic capture_now(input logic rw_n, input logic en);
        return rw_n & en;
    endfunction

endpackage

// File: rtl/bad_bank_latch.sv
module bad_bank_latch #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] bank_in,
    output logic [BANK_W-1:0] bank_q
);

    always_latch begin
        if (!clk)
            bank_q = bank_in;
    end

    logic              seen_rise;
    logic [BANK_W-1:0] bank_at_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_rise    <= 1'b0;
            bank_at_rise <= '0;
        end else begin
            seen_rise    <= 1'b1;
            bank_at_rise <= bank_q;
        end
    end

    p_bank_hold_r2: assert property (@(negedge clk) disable iff (rst || !seen_rise)
        bank_q == bank_at_rise)
        else $error("bank byte moved during data half");

endmodule

// File: rtl/bad_pin_mux.sv
module bad_pin_mux
    import bad_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              bus_en,
    input  logic              rw_n,
    input  logic [DATA_W-1:0] bank_q,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pins_o,
    output logic              pins_oe
);

    phase_t ph;

    always_comb begin
        ph      = phase_of(clk);
        pins_oe = shared_drive(ph, rw_n, bus_en);
        case (ph)
            PH_ADDR: pins_o = bank_q;
            default: pins_o = wdata;
        endcase
    end

endmodule

// File: rtl/bad_read_capture.sv
module bad_read_capture
    import bad_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rw_n,
    input  logic              bus_en,
    input  logic [DATA_W-1:0] pins_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    always_ff @(negedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (capture_now(rw_n, bus_en)) begin
            rd_data  <= pins_i;
            rd_valid <= 1'b1;
        end else begin
            rd_valid <= 1'b0;
        end
    end

    p_capture_r6: assert property (@(negedge clk) disable iff (rst)
        (rw_n && bus_en) |=> (rd_valid && rd_data == $past(pins_i)))
        else $error("read byte not captured");

    p_hold_r7: assert property (@(negedge clk) disable iff (rst)
        (!rw_n || !bus_en) |=> (!rd_valid && $stable(rd_data)))
        else $error("capture register moved without a read");

endmodule

// File: rtl/bank_addr_demux.sv
module bank_addr_demux
    import bad_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              core_rw_n,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] pins_i,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              addr_oe,
    output logic              rw_o,
    output logic              rw_oe,
    output logic [DATA_W-1:0] pins_o,
    output logic              pins_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int LOW_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] bank_q;

    bad_bank_latch #(.BANK_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .bank_in (core_addr[ADDR_W-1:LOW_W]),
        .bank_q  (bank_q)
    );

    bad_pin_mux #(.DATA_W(DATA_W)) u_mux (
        .clk     (clk),
        .bus_en  (bus_en),
        .rw_n    (core_rw_n),
        .bank_q  (bank_q),
        .wdata   (core_wdata),
        .pins_o  (pins_o),
        .pins_oe (pins_oe)
    );

    bad_read_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .rw_n     (core_rw_n),
        .bus_en   (bus_en),
        .pins_i   (pins_i),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always_comb begin
        ext_addr = {bank_q, core_addr[LOW_W-1:0]};
        addr_oe  = bus_en;
        rw_o     = core_rw_n;
        rw_oe    = bus_en;
    end

    always_comb begin
        if (clk && core_rw_n)
            a_read_quiet_r4: assert (!pins_oe) else $error("pins driven in read data half");
        if (clk && !core_rw_n && bus_en)
            a_write_drive_r3: assert (pins_oe && pins_o == core_wdata)
                else $error("write byte not on pins");
        if (!bus_en)
            a_pins_quiet_r5: assert (!pins_oe && !addr_oe && !rw_oe)
                else $error("driver on while bus released");
    end

endmodule

// File: tb/tb_bank_addr_demux.sv
`timescale 1ns/100ps
module tb_bank_addr_demux;

    logic        clk = 1'b1;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        core_rw_n = 1'b1;
    logic [23:0] core_addr = '0;
    logic [7:0]  core_wdata = '0;
    logic [7:0]  pins_i;
    logic [23:0] ext_addr;
    logic        addr_oe, rw_o, rw_oe, pins_oe, rd_valid;
    logic [7:0]  pins_o, rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[23:16] ^ 8'h5A;
    endfunction

    assign pins_i = mem_byte(ext_addr);

    bank_addr_demux dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .core_rw_n(core_rw_n),
        .core_addr(core_addr), .core_wdata(core_wdata), .pins_i(pins_i),
        .ext_addr(ext_addr), .addr_oe(addr_oe), .rw_o(rw_o), .rw_oe(rw_oe),
        .pins_o(pins_o), .pins_oe(pins_oe), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // {rw_n, bus_en, addr, wdata}
    localparam logic [33:0] VEC [10] = '{
        {1'b1, 1'b1, 24'h12_3456, 8'h00},
        {1'b0, 1'b1, 24'hAB_0010, 8'hC3},
        {1'b1, 1'b1, 24'hFF_FFFF, 8'h00},
        {1'b0, 1'b1, 24'h00_0000, 8'h7E},
        {1'b1, 1'b0, 24'h40_1234, 8'h00},
        {1'b1, 1'b1, 24'h7F_8001, 8'h00},
        {1'b1, 1'b1, 24'h7F_8002, 8'h00},
        {1'b0, 1'b0, 24'h55_AAAA, 8'h99},
        {1'b0, 1'b1, 24'h80_00FF, 8'hFF},
        {1'b1, 1'b1, 24'h01_FFFE, 8'h00}
    };

    bit         prev_cap  = 0;
    logic [7:0] prev_byte = '0;
    logic [7:0] held      = '0;

    task automatic check_prev();
        if (prev_cap) begin
            check(rd_valid === 1'b1, "R6 valid", {31'd0, rd_valid}, 32'd1);
            check(rd_data === prev_byte, "R6 data", {24'd0, rd_data}, {24'd0, prev_byte});
            held = prev_byte;
        end else begin
            check(rd_valid === 1'b0, "R7 valid", {31'd0, rd_valid}, 32'd0);
            check(rd_data === held, "R7 data held", {24'd0, rd_data}, {24'd0, held});
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5 rst = 1'b0;
        #0.5;
        check(rd_valid === 1'b0, "R8 reset valid", {31'd0, rd_valid}, 32'd0);
        check(rd_data === 8'h00, "R8 reset data", {24'd0, rd_data}, 32'd0);
        check(!pins_oe && !addr_oe && !rw_oe, "R5 idle released", {31'd0, pins_oe}, 32'd0);

        for (int i = 0; i < 10; i++) begin
            logic rw, en;
            logic [23:0] a;
            logic [7:0]  w;
            {rw, en, a, w} = VEC[i];
            @(negedge clk);
            #0.2 check_prev();
            #0.3;
            core_rw_n = rw; bus_en = en; core_addr = a; core_wdata = w;
            #0.5;
            // address half
            check(ext_addr === a, "R1 ext_addr", {8'd0, ext_addr}, {8'd0, a});
            check(rw_o === rw, "R9 strobe", {31'd0, rw_o}, {31'd0, rw});
            check(rw_oe === en && addr_oe === en, "R9/R5 enables", {31'd0, rw_oe}, {31'd0, en});
            if (en) begin
                check(pins_oe === 1'b1, "R1 oe", {31'd0, pins_oe}, 32'd1);
                check(pins_o === a[23:16], "R1 bank on pins", {24'd0, pins_o}, {24'd0, a[23:16]});
            end else begin
                check(pins_oe === 1'b0, "R5 oe low phase", {31'd0, pins_oe}, 32'd0);
            end
            @(posedge clk);
            #0.5;
            // data half
            if (rw) check(pins_oe === 1'b0, "R4 read quiet", {31'd0, pins_oe}, 32'd0);
            else if (en) begin
                check(pins_oe === 1'b1, "R3 write oe", {31'd0, pins_oe}, 32'd1);
                check(pins_o === w, "R3 write byte", {24'd0, pins_o}, {24'd0, w});
            end else check(pins_oe === 1'b0, "R5 oe high phase", {31'd0, pins_oe}, 32'd0);
            #0.1 core_addr = {a[23:16] ^ 8'hA5, a[15:0] ^ 16'h0F0F};
            #0.3;
            check(ext_addr[23:16] === a[23:16], "R2 bank held",
                  {24'd0, ext_addr[23:16]}, {24'd0, a[23:16]});
            check(ext_addr[15:0] === (a[15:0] ^ 16'h0F0F), "R2 low follows",
                  {16'd0, ext_addr[15:0]}, {16'd0, a[15:0] ^ 16'h0F0F});
            #0.6 core_addr = a;
            prev_cap  = rw && en;
            prev_byte = mem_byte(a);
        end
        @(negedge clk);
        #0.2 check_prev();

        // R5: release mid data half of a write
        #0.3;
        core_rw_n = 1'b0; bus_en = 1'b1; core_addr = 24'h3C_0101; core_wdata = 8'h42;
        @(posedge clk);
        #0.5 check(pins_oe === 1'b1, "R3 before release", {31'd0, pins_oe}, 32'd1);
        #0.2 bus_en = 1'b0;
        #0.1 check(!pins_oe && !addr_oe && !rw_oe, "R5 async release",
                   {29'd0, pins_oe, addr_oe, rw_oe}, 32'd0);

        // read then reset
        @(negedge clk);
        #0.2 check(rd_valid === 1'b0, "R7 write closed", {31'd0, rd_valid}, 32'd0);
        #0.3 core_rw_n = 1'b1; bus_en = 1'b1; core_addr = 24'hC0_0033;
        @(negedge clk);
        #0.2 check(rd_valid === 1'b1 && rd_data === mem_byte(24'hC0_0033), "R6 late read",
                   {24'd0, rd_data}, {24'd0, mem_byte(24'hC0_0033)});
        #0.3 rst = 1'b1;
        @(negedge clk);
        #0.2 check(rd_valid === 1'b0 && rd_data === 8'h00, "R8 reset clears",
                   {23'd0, rd_valid, rd_data}, 32'd0);
        #0.3 rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule